// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register

This block holds the interrupt state of a ten-channel DMA controller in one 32-bit register. The lower half stores sticky event flags: one completion flag per channel, and a bus-error flag at bit 15. Hardware sets these flags with single-cycle pulses. The upper half stores one enable bit per flag, at the flag's position plus 16. A single interrupt request goes high whenever any flag and its enable bit are both set.

Software reaches the register through a simple write port and a combinational read port. On a write, the two halves are treated differently. A one in the lower half clears the matching flag. A one in the upper half inverts the matching enable bit. Writes are accepted at the primary status address and at a second alias address, and the two have the same effect. The interrupt output is driven only from register state, so it reflects a write in the cycle after that write.

Top module: `dma_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all 32 register bits read as zero and `irq` is low.
- R2: A pulse on `ch_done[n]` sets register bit n (n = 0..9) on the next clock edge. The flag then stays set until software clears it.
- R3: A pulse on `bus_err` sets register bit 15 on the next clock edge, and the flag then stays set.
- R4: A write to the status address (`8'h10`) clears every flag in bits 15:0 whose data bit is one. Flags whose data bit is zero are not changed.
- R5: The same write inverts every enable bit in bits 31:16 whose data bit is one. Enable bits whose data bit is zero are not changed.
- R6: A write to the alias address (`8'h40`) has exactly the same effect as a write to the status address.
- R7: If a hardware set pulse and a software clear hit the same flag in the same cycle, the flag is set afterwards.
- R8: `irq` is high exactly when some flag bit k (k in 0..9 or 15) and its enable bit k+16 are both one. It reflects a register update in the cycle right after that update.
- R9: `rd_data` returns the full register when `rd_addr` is the status or alias address, and zero at any other address. A read changes nothing.
- R10: Bits 14:10 and 30:26 always read as zero, whatever data is written.
- R11: A write to any other address changes no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data: clear mask in the low half, toggle mask in the high half |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| ch_done | input | 10 | Per-channel flag set pulses |
| bus_err | input | 1 | Bus-error flag set pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can meet in the same cycle: a hardware set pulse and a software write-one-to-clear aimed at the same flag. The bench drives `ch_done` or `bus_err` in the same cycle as a clearing write, to either address, that names that bit. It then expects the flag still set one cycle later, and `irq` to follow the enable bit. A bench model computes the expected register after every cycle and compares it against the register read through `rd_data`.

// File: rtl/dis_pkg.sv
// Package: shared sizes and field positions of the DMA interrupt status register.
// Assumes a 32-bit register split into a 16-bit flag half and a 16-bit enable half.
package dis_pkg;
    localparam int REG_W     = 32;
    localparam int HALF_W    = REG_W / 2;
    localparam int NUM_CH    = 10;
    localparam int ERR_POS   = 15;
    localparam int NFLAG     = NUM_CH + 1;   // channel flags plus the error flag
    localparam int ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 8'h10;
    localparam logic [ADDR_W-1:0] ALIAS_ADDR = 8'h40;
endpackage

// File: rtl/dis_wr_decode.sv
// Module: decodes a register write into a per-flag clear vector and a per-enable toggle vector.
// Assumes a flag index below NUM_CH maps to register bit index, and index NUM_CH maps to ERR_POS.
module dis_wr_decode
    import dis_pkg::*;
#(
    parameter int                 N_CH   = NUM_CH,
    parameter int                 E_POS  = ERR_POS,
    parameter int                 AW     = ADDR_W,
    parameter logic [ADDR_W-1:0]  A_MAIN = STAT_ADDR,
    parameter logic [ADDR_W-1:0]  A_ALT  = ALIAS_ADDR
) (
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic              hit_o,
    output logic [N_CH:0]     clr_o,
    output logic [N_CH:0]     tgl_o
);
    localparam int NF = N_CH + 1;

    // Address match: either the status address or its alias.
    always_comb begin
        hit_o = wr_en_i && ((wr_addr_i == A_MAIN) || (wr_addr_i == A_ALT));
    end

    // Gather data bits into flag order, masked by the write hit.
    for (genvar k = 0; k < NF; k++) begin : g_map
        localparam int POS = (k < N_CH) ? k : E_POS;
        assign clr_o[k] = hit_o & wr_data_i[POS];
        assign tgl_o[k] = hit_o & wr_data_i[HALF_W + POS];
    end
endmodule

// File: rtl/dis_flag_bank.sv
// Module: sticky event flags; hardware set has priority over software clear.
// Assumes set and clear vectors are single-cycle and aligned to the flag index.
module dis_flag_bank #(
    parameter int NF = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flag_o
);
    // Update flags: clear selected bits, then apply set pulses on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_i) | set_i;
    end

    // R7 / R2: a set pulse always lands, even against a clear.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    // R4: a cleared bit with no competing set is zero afterwards.
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((flag_o & $past(clr_i) & ~$past(set_i)) == '0));

    // R2: without a clear, no flag ever falls.
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));
endmodule

// File: rtl/dis_mask_bank.sv
// Module: enable bits that invert wherever the toggle vector holds a one.
// Assumes the toggle vector is already qualified by a valid write.
module dis_mask_bank #(
    parameter int NF = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] tgl_i,
    output logic [NF-1:0] en_o
);
    // Toggle selected enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en_o <= '0;
        else        en_o <= en_o ^ tgl_i;
    end

    // R5: bits outside the toggle vector hold their value.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((en_o ^ $past(en_o)) & ~$past(tgl_i)) == '0));
endmodule

// File: rtl/dis_irq_merge.sv
// Module: reduces flag-and-enable pairs to one interrupt request.
// Assumes flags and enables share the same index order.
module dis_irq_merge #(
    parameter int NF = 11
) (
    input  logic [NF-1:0] flag_i,
    input  logic [NF-1:0] en_i,
    output logic          irq_o
);
    // OR across all enabled flags.
    always_comb begin
        irq_o = |(flag_i & en_i);
    end
endmodule

// File: rtl/dma_irq_status.sv
// Module: DMA interrupt status/mask register with write-one-to-clear flags,
// write-one-to-toggle enables, an alias write address and a combined interrupt.
// Assumes single-cycle set pulses and one write per cycle at most.
module dma_irq_status
    import dis_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_CH-1:0]  ch_done,
    input  logic               bus_err,
    output logic               irq
);
    logic             wr_hit;
    logic [NFLAG-1:0] clr_vec;
    logic [NFLAG-1:0] tgl_vec;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] enables;
    logic [REG_W-1:0] reg_view;

    // Collect hardware set pulses into flag order.
    always_comb begin
        set_vec = {bus_err, ch_done};
    end

    dis_wr_decode u_dec (
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .hit_o     (wr_hit),
        .clr_o     (clr_vec),
        .tgl_o     (tgl_vec)
    );

    dis_flag_bank #(.NF(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags)
    );

    dis_mask_bank #(.NF(NFLAG)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl_i (tgl_vec),
        .en_o  (enables)
    );

    dis_irq_merge #(.NF(NFLAG)) u_irq (
        .flag_i (flags),
        .en_i   (enables),
        .irq_o  (irq)
    );

    // Assemble the 32-bit register image; unused positions stay zero.
    always_comb begin
        reg_view                       = '0;
        reg_view[NUM_CH-1:0]           = flags[NUM_CH-1:0];
        reg_view[ERR_POS]              = flags[NUM_CH];
        reg_view[HALF_W +: NUM_CH]     = enables[NUM_CH-1:0];
        reg_view[HALF_W + ERR_POS]     = enables[NUM_CH];
    end

    // Read mux: register at either address, zero elsewhere.
    always_comb begin
        if ((rd_addr == STAT_ADDR) || (rd_addr == ALIAS_ADDR)) rd_data = reg_view;
        else                                                    rd_data = '0;
    end

    // R10: reserved positions never hold a one.
    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_view[14:10] == '0) && (reg_view[30:26] == '0));

    // R8: a raised request always has an enabled flag behind it.
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & enables) != '0));

    // R11: a write elsewhere leaves the enables alone.
    p_foreign_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != STAT_ADDR) && (wr_addr != ALIAS_ADDR)) |=> $stable(enables));

    // R6: a write at the alias inverts the named channel-0 enable bit.
    p_alias_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ALIAS_ADDR) && wr_data[HALF_W]) |=> (enables[0] != $past(enables[0])));
endmodule

// File: tb/dma_irq_status_bench.sv
module dma_irq_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_ALIAS = 8'h40;
    localparam logic [31:0] IMPL   = 32'h83FF_83FF;

    typedef struct {
        logic [31:0] stat;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = A_STAT;
    logic [31:0] rd_data;
    logic [9:0]  ch_done = '0;
    logic        bus_err = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t q[$];
    logic [31:0] model = '0;
    bit reset_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status u_dma_irq_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ch_done(ch_done), .bus_err(bus_err), .irq(irq)
    );

    function automatic logic model_irq(logic [31:0] s);
        return |(s[15:0] & s[31:16]);
    endfunction

    // Driver: apply one cycle of stimulus, update the model, queue the expectation.
    task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [9:0] cd, input logic be, input string tag);
        logic [31:0] nxt;
        logic        hit;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; ch_done = cd; bus_err = be;
        hit = we && (a == A_STAT || a == A_ALIAS);
        nxt = model;
        if (hit) begin
            nxt[15:0]  = nxt[15:0] & ~(d[15:0] & IMPL[15:0]);
            nxt[31:16] = nxt[31:16] ^ (d[31:16] & IMPL[31:16]);
        end
        nxt[9:0] = nxt[9:0] | cd;
        if (be) nxt[15] = 1'b1;
        model = nxt;
        q.push_back('{stat: nxt, irq: model_irq(nxt), tag: tag});
    endtask

    task automatic idle();
        op(1'b0, 8'h00, 32'h0, 10'h0, 1'b0, "idle");
    endtask

    // Monitor: a quarter period after each edge, compare the register and irq.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (reset_done && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (rd_data !== e.stat || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: got reg=%h irq=%b expected reg=%h irq=%b",
                         e.tag, rd_data, irq, e.stat, e.irq);
            end
        end
    end

    task automatic direct(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        direct(rd_data, 32'h0, "R1 reset register");
        direct({31'h0, irq}, 32'h0, "R1 reset irq");
        reset_done = 1'b1;

        op(1'b0, 8'h00, 32'h0, 10'h201, 1'b0, "R2 set ch0 and ch9");
        op(1'b0, 8'h00, 32'h0, 10'h000, 1'b1, "R3 bus error flag");
        idle();
        op(1'b1, A_STAT, 32'h0000_0001, 10'h0, 1'b0, "R4 clear ch0 only");
        op(1'b1, A_STAT, 32'h0200_0000, 10'h0, 1'b0, "R5 R8 enable ch9 raises irq");
        op(1'b1, A_STAT, 32'h0200_0000, 10'h0, 1'b0, "R5 R8 toggle back drops irq");
        op(1'b1, A_STAT, 32'h8000_0000, 10'h0, 1'b0, "R8 error enable raises irq");
        op(1'b1, A_ALIAS, 32'h0000_8000, 10'h0, 1'b0, "R6 alias clears error flag");
        op(1'b1, A_ALIAS, 32'h0001_0000, 10'h0, 1'b0, "R6 alias toggles ch0 enable");
        op(1'b1, A_STAT, 32'h0000_0008, 10'h008, 1'b0, "R7 set and clear ch3 same cycle");
        op(1'b1, A_ALIAS, 32'h0000_8000, 10'h0, 1'b1, "R7 set and clear error via alias");
        op(1'b1, A_STAT, 32'h7C00_7C00, 10'h0, 1'b0, "R10 reserved bits stay zero");
        op(1'b1, 8'h20, 32'hFFFF_FFFF, 10'h0, 1'b0, "R11 foreign address write ignored");
        op(1'b1, A_STAT, 32'h0000_03FF, 10'h001, 1'b0, "R7 R4 clear all channels, ch0 kept");
        op(1'b1, A_STAT, 32'h03FF_0000, 10'h0, 1'b0, "R5 toggle all channel enables");
        idle();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);

        rd_addr = 8'h30;
        #1 direct(rd_data, 32'h0, "R9 read at other address");
        rd_addr = A_ALIAS;
        #1 direct(rd_data, model, "R9 read at alias address");
        rd_addr = A_STAT;
        @(negedge clk);
        direct(rd_data, model, "R9 reads leave register unchanged");

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        @(negedge clk);
        direct(rd_data, 32'h0, "R1 second reset register");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule